// File: doc/BRIEF.md
# Programmable Reference Sequencer with Soft-Start

This block generates the digital set-point for a multiphase buck regulator as a word in millivolt units. A 5-bit voltage code selects the target. After an enable, the reference climbs from zero to that target along a fixed-length soft-start ramp. Once the ramp has finished, the block follows later code changes. A changed code is taken only after two consecutive samples agree. The reference then walks toward the new value one step per tick, and the inputs are not looked at again until the walk has ended.

All state moves only on a tick input, which is synchronous with the PWM ramp. The all-ones code is a shutdown request. When it is seen, the block drops the reference to zero and latches that state until reset. The analog DAC, the error amplifier and the PWM lie outside this block.

Top module: `ref_seq_top`

## Requirements
- R1: The target in mV is 1575 − 25·code for codes 0 to 30, so code 0 gives 1575 and code 30 gives 825. It is latched into `target_mv` when the code is taken.
- R2: While `rst` is high on a clock edge, every output is cleared to zero.
- R3: State changes only on clock edges where `tick` is 1. With `tick` at 0, all outputs hold their values.
- R4: In the idle state, a tick with `start_en`=1 latches the target and sets `ref_mv` to 0. On the k-th tick after that, `ref_mv` = floor(target·k/2048) for k = 1 to 2046. On tick 2047, `ref_mv` equals the target and `ss_done` rises.
- R5: Codes other than 31 that arrive during soft-start are ignored: `target_mv` stays unchanged.
- R6: After soft-start, when no walk is in progress, a code different from the current one is taken on a tick where it equals the code sampled on the previous tick. A code held for only one tick is not taken.
- R7: On the tick that takes a code, and on every following tick, `ref_mv` moves 25 mV toward the target. `slewing` is 1 after any step that leaves `ref_mv` different from the target, and 0 otherwise.
- R8: Codes that arrive while `slewing` is 1 are ignored. A code that is stable when the walk ends is taken on the next tick.
- R9: Code 31 sampled on any tick sets `nocpu` to 1 and clears `ref_mv`, `ss_done` and `slewing`. This state is held until reset, whatever the inputs.
- R10: After reset the block stays idle, with all outputs at zero, until a tick arrives with `start_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Enable, once per PWM ramp period |
| start_en | input | 1 | Starts soft-start from the idle state |
| vid | input | 5 | Voltage code |
| ref_mv | output | 11 | Reference word, 1 mV per LSB |
| target_mv | output | 11 | Latched target word, mV |
| ss_done | output | 1 | Soft-start has finished |
| slewing | output | 1 | Code-change walk in progress |
| nocpu | output | 1 | Latched shutdown |

## Verification
Two functions can act on the same tick. A shutdown code can arrive while a walk is stepping, and a newly stable code can arrive on the very tick that ends a walk. The bench forces both: it drives code 31 partway through a walk, and it holds a new code steady across a walk so that the code is pending when the walk finishes. A reference model built from the requirements predicts the result on every cycle. It expects the shutdown to win outright, and it expects the pending code to be taken one tick after the walk ends.

// File: rtl/ref_seq_pkg.sv
package ref_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SOFT = 2'd1,
      PH_RUN  = 2'd2,
      PH_HALT = 2'd3
   } phase_e;
endpackage

// File: rtl/vid_decode.sv
module vid_decode #(
   parameter int CODE_W  = 5,
   parameter int REF_W   = 11,
   parameter int TOP_MV  = 1575,
   parameter int STEP_MV = 25
) (
   input  logic [CODE_W-1:0] code,
   output logic [REF_W-1:0]  mv
);
   always_comb begin
      mv = REF_W'(TOP_MV - STEP_MV * int'(code));
   end
endmodule

// File: rtl/vid_filter.sv
module vid_filter #(
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic [CODE_W-1:0] vid,
   output logic              stable
);
   logic [CODE_W-1:0] cand_q;

   always_ff @(posedge clk) begin
      if (rst)       cand_q <= '0;
      else if (tick) cand_q <= vid;
   end

   assign stable = (vid == cand_q);
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen #(
   parameter int REF_W = 11,
   parameter int SS_W  = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             adv,
   input  logic [REF_W-1:0] target,
   output logic [REF_W-1:0] ramp_mv,
   output logic             last
);
   localparam int PROD_W = REF_W + SS_W + 1;
   localparam logic [SS_W-1:0] LAST_CNT = SS_W'((1 << SS_W) - 2);

   logic [SS_W-1:0]   cnt_q;
   logic [SS_W:0]     cnt_p1;
   logic [PROD_W-1:0] prod;

   always_ff @(posedge clk) begin
      if (rst || clr) cnt_q <= '0;
      else if (adv)   cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_p1  = {1'b0, cnt_q} + 1'b1;
   assign prod    = PROD_W'(target) * PROD_W'(cnt_p1);
   assign ramp_mv = REF_W'(prod >> SS_W);
   assign last    = (cnt_q == LAST_CNT);
endmodule

// File: rtl/slew_step.sv
module slew_step #(
   parameter int REF_W   = 11,
   parameter int STEP_MV = 25
) (
   input  logic [REF_W-1:0] cur,
   input  logic [REF_W-1:0] goal,
   output logic [REF_W-1:0] nxt
);
   localparam logic [REF_W-1:0] STEP = REF_W'(STEP_MV);

   always_comb begin
      if (cur < goal)      nxt = cur + STEP;
      else if (cur > goal) nxt = cur - STEP;
      else                 nxt = cur;
   end
endmodule

// File: rtl/ref_seq_top.sv
module ref_seq_top #(
   parameter int CODE_W    = 5,
   parameter int REF_W     = 11,
   parameter int SS_W      = 11,
   parameter int BASE_MV   = 1550,
   parameter int OFFSET_MV = 25,
   parameter int STEP_MV   = 25
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              start_en,
   input  logic [CODE_W-1:0] vid,
   output logic [REF_W-1:0]  ref_mv,
   output logic [REF_W-1:0]  target_mv,
   output logic              ss_done,
   output logic              slewing,
   output logic              nocpu
);
   import ref_seq_pkg::*;

   localparam int TOP_MV = BASE_MV + OFFSET_MV;
   localparam int LOW_MV = TOP_MV - STEP_MV * ((1 << CODE_W) - 2);
   localparam logic [CODE_W-1:0] SHUT_CODE = '1;

   if (TOP_MV >= (1 << REF_W)) begin : g_bad_width
      $error("REF_W too narrow for the top target");
   end
   if (LOW_MV <= 0) begin : g_bad_range
      $error("lowest target must be positive");
   end
   if (SS_W < 2) begin : g_bad_ss
      $error("SS_W must be at least 2");
   end

   phase_e            phase_q;
   logic [REF_W-1:0]  ref_q, tgt_q;
   logic [CODE_W-1:0] code_q;
   logic              done_q, slew_q, noc_q;

   logic [REF_W-1:0]  dec_mv, ramp_mv, step_mv, goal_mv;
   logic              stable, ramp_last, shut_req, accept, live;

   vid_decode #(.CODE_W(CODE_W), .REF_W(REF_W), .TOP_MV(TOP_MV), .STEP_MV(STEP_MV))
      u_dec (.code(vid), .mv(dec_mv));

   vid_filter #(.CODE_W(CODE_W))
      u_flt (.clk(clk), .rst(rst), .tick(tick), .vid(vid), .stable(stable));

   assign shut_req = (vid == SHUT_CODE);
   assign live     = tick && !noc_q && !shut_req;

   ramp_gen #(.REF_W(REF_W), .SS_W(SS_W))
      u_ramp (.clk(clk), .rst(rst),
              .clr(live && phase_q == PH_IDLE && start_en),
              .adv(live && phase_q == PH_SOFT),
              .target(tgt_q), .ramp_mv(ramp_mv), .last(ramp_last));

   assign accept  = (phase_q == PH_RUN) && !slew_q && stable && (vid != code_q);
   assign goal_mv = accept ? dec_mv : tgt_q;

   slew_step #(.REF_W(REF_W), .STEP_MV(STEP_MV))
      u_step (.cur(ref_q), .goal(goal_mv), .nxt(step_mv));

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         ref_q   <= '0;
         tgt_q   <= '0;
         code_q  <= '0;
         done_q  <= 1'b0;
         slew_q  <= 1'b0;
         noc_q   <= 1'b0;
      end else if (tick && !noc_q) begin
         if (shut_req) begin
            noc_q   <= 1'b1;
            ref_q   <= '0;
            done_q  <= 1'b0;
            slew_q  <= 1'b0;
            phase_q <= PH_HALT;
         end else begin
            unique case (phase_q)
               PH_IDLE: if (start_en) begin
                  tgt_q   <= dec_mv;
                  code_q  <= vid;
                  ref_q   <= '0;
                  phase_q <= PH_SOFT;
               end
               PH_SOFT: if (ramp_last) begin
                  ref_q   <= tgt_q;
                  done_q  <= 1'b1;
                  phase_q <= PH_RUN;
               end else begin
                  ref_q   <= ramp_mv;
               end
               PH_RUN: if (slew_q) begin
                  ref_q  <= step_mv;
                  slew_q <= (step_mv != tgt_q);
               end else if (accept) begin
                  tgt_q  <= dec_mv;
                  code_q <= vid;
                  ref_q  <= step_mv;
                  slew_q <= (step_mv != dec_mv);
               end
               default: ;
            endcase
         end
      end
   end

   assign ref_mv    = ref_q;
   assign target_mv = tgt_q;
   assign ss_done   = done_q;
   assign slewing   = slew_q;
   assign nocpu     = noc_q;
endmodule

// File: rtl/ref_seq_chk.sv
module ref_seq_chk #(
   parameter int REF_W   = 11,
   parameter int STEP_MV = 25
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic [REF_W-1:0] ref_mv,
   input logic [REF_W-1:0] target_mv,
   input logic             ss_done,
   input logic             slewing,
   input logic             nocpu
);
   p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(ref_mv) && $stable(target_mv) && $stable(nocpu) && $stable(ss_done));

   p_ramp_below_r4: assert property (@(posedge clk) disable iff (rst)
      (!ss_done && !nocpu) |-> (ref_mv <= target_mv));

   p_step_size_r7: assert property (@(posedge clk) disable iff (rst)
      (tick && slewing && !nocpu) |=>
         nocpu || (32'(ref_mv) == 32'($past(ref_mv)) + STEP_MV)
               || (32'(ref_mv) + STEP_MV == 32'($past(ref_mv))));

   p_target_frozen_r8: assert property (@(posedge clk) disable iff (rst)
      slewing |=> $stable(target_mv) || nocpu);

   p_shut_latched_r9: assert property (@(posedge clk) disable iff (rst)
      nocpu |=> nocpu);

   p_shut_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      nocpu |-> (ref_mv == '0) && !slewing && !ss_done);
endmodule

bind ref_seq_top ref_seq_chk #(.REF_W(REF_W), .STEP_MV(STEP_MV)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .ref_mv(ref_mv), .target_mv(target_mv),
   .ss_done(ss_done), .slewing(slewing), .nocpu(nocpu));

// File: tb/tb_ref_seq_top.sv
`timescale 1ns/1ps
module tb_ref_seq_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst = 1'b1, tick = 1'b0, start_en = 1'b0;
   logic [4:0]  vid = '0;
   logic [10:0] ref_mv, target_mv;
   logic        ss_done, slewing, nocpu;

   ref_seq_top dut (.clk(clk), .rst(rst), .tick(tick), .start_en(start_en), .vid(vid),
                    .ref_mv(ref_mv), .target_mv(target_mv), .ss_done(ss_done),
                    .slewing(slewing), .nocpu(nocpu));

   int n_chk = 0, n_err = 0;
   // model state: ph 0 idle, 1 soft, 2 run, 3 halt
   int m_ph, m_k, m_ref, m_tgt, m_code, m_cand, m_done, m_slew, m_noc;

   function automatic int dec(int v); return 1575 - 25 * v; endfunction
   function automatic int toward(int cur, int goal);
      if (cur < goal) return cur + 25;
      if (cur > goal) return cur - 25;
      return cur;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic m_step(bit r, bit t, bit s, int v);
      int old;
      if (r) begin
         m_ph = 0; m_k = 0; m_ref = 0; m_tgt = 0; m_code = 0;
         m_cand = 0; m_done = 0; m_slew = 0; m_noc = 0;
         return;
      end
      if (!t) return;
      old = m_cand; m_cand = v;
      if (m_noc) return;
      if (v == 31) begin
         m_noc = 1; m_ref = 0; m_slew = 0; m_done = 0; m_ph = 3;
         return;
      end
      case (m_ph)
         0: if (s) begin m_tgt = dec(v); m_code = v; m_ref = 0; m_k = 0; m_ph = 1; end
         1: begin
            m_k++;
            if (m_k == 2047) begin m_ref = m_tgt; m_done = 1; m_ph = 2; end
            else m_ref = (m_tgt * m_k) / 2048;
         end
         2: if (m_slew) begin
            m_ref = toward(m_ref, m_tgt); m_slew = (m_ref != m_tgt);
         end else if (v == old && v != m_code) begin
            m_code = v; m_tgt = dec(v);
            m_ref = toward(m_ref, m_tgt); m_slew = (m_ref != m_tgt);
         end
         default: ;
      endcase
   endtask

   task automatic cyc(string tag, bit r, bit t, bit s, int v);
      rst = r; tick = t; start_en = s; vid = 5'(v);
      @(posedge clk);
      @(negedge clk);
      m_step(r, t, s, v);
      chk({tag, " ref_mv"},    ref_mv,    m_ref);
      chk({tag, " target_mv"}, target_mv, m_tgt);
      chk({tag, " ss_done"},   ss_done,   m_done);
      chk({tag, " slewing"},   slewing,   m_slew);
      chk({tag, " nocpu"},     nocpu,     m_noc);
   endtask

   task automatic do_reset();
      for (int i = 0; i < 3; i++) cyc("R2", 1, 1, 0, 0);
   endtask

   // random run after soft-start: codes 0..30 held 1..6 ticks
   task automatic run_random(string tag, int n, int pct);
      int v = 0, hold = 0;
      for (int i = 0; i < n; i++) begin
         if (hold == 0) begin v = $urandom_range(30); hold = $urandom_range(6, 1); end
         hold--;
         cyc(tag, 0, ($urandom_range(99) < pct), 0, v);
      end
   endtask

   task automatic soft_start(string tag, int code, int pct);
      cyc("R4", 0, 1, 1, code);
      while (!ss_done) cyc(tag, 0, ($urandom_range(99) < pct), 0,
                           ($urandom_range(3) == 0) ? $urandom_range(30) : code);
   endtask

   initial begin
      #(8 * 200000);
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();
      chk("R2 reset ref", ref_mv, 0);
      chk("R2 reset flags", {ss_done, slewing, nocpu}, 0);

      // R10: idle without start
      for (int i = 0; i < 6; i++) cyc("R10", 0, 1, 0, $urandom_range(30));
      chk("R10 idle ref", ref_mv, 0);

      // R1 and R4: code 0, every-cycle ticks, codes changing during ramp (R5)
      cyc("R4", 0, 1, 1, 0);
      chk("R1 code0 target", target_mv, 1575);
      for (int k = 1; k < 2047; k++) begin
         cyc("R5", 0, 1, 0, $urandom_range(30));
         if (k == 1024) chk("R4 mid ramp", ref_mv, 787);
         if (k == 2046) chk("R4 not yet done", ss_done, 0);
      end
      cyc("R4", 0, 1, 0, 0);
      chk("R4 done", ss_done, 1);
      chk("R4 final ref", ref_mv, 1575);
      chk("R5 target kept", target_mv, 1575);

      // R3: no tick -> hold
      for (int i = 0; i < 5; i++) cyc("R3", 0, 0, 0, 12);
      chk("R3 held", ref_mv, 1575);

      // R6: single-tick glitch not accepted
      cyc("R6", 0, 1, 0, 9);
      cyc("R6", 0, 1, 0, 0);
      chk("R6 glitch ignored", target_mv, 1575);

      // R1, R7: walk to code 30
      cyc("R7", 0, 1, 0, 30);
      cyc("R7", 0, 1, 0, 30);
      chk("R1 code30 target", target_mv, 825);
      chk("R7 first step", ref_mv, 1550);
      chk("R7 slewing", slewing, 1);
      // R8: new code stable during walk, pending when walk ends
      for (int i = 0; i < 29; i++) cyc("R8", 0, 1, 0, 20);
      chk("R8 walk ended", ref_mv, 825);
      chk("R8 target unchanged", target_mv, 825);
      cyc("R8", 0, 1, 0, 20);
      chk("R8 pending taken", target_mv, 1075);
      chk("R7 step up", ref_mv, 850);

      run_random("R6", 1500, 70);

      // R9: shutdown mid-walk
      cyc("R9", 0, 1, 0, 0);
      cyc("R9", 0, 1, 0, 0);
      while (!slewing) begin cyc("R9", 0, 1, 0, 30); cyc("R9", 0, 1, 0, 30); end
      cyc("R9", 0, 1, 0, 31);
      chk("R9 nocpu", nocpu, 1);
      chk("R9 ref zero", ref_mv, 0);
      for (int i = 0; i < 40; i++)
         cyc("R9", 0, $urandom_range(1), $urandom_range(1), $urandom_range(31));
      chk("R9 held", nocpu, 1);

      // R10: reset restarts; shutdown from idle
      do_reset();
      chk("R10 nocpu cleared", nocpu, 0);
      cyc("R9", 0, 1, 1, 31);
      chk("R9 idle shutdown", nocpu, 1);

      // sparse ticks, another code
      do_reset();
      soft_start("R3", 17, 60);
      chk("R4 done code17", ref_mv, dec(17));
      run_random("R7", 1500, 50);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule